// File: doc/BRIEF.md
# Double-Buffered Serial DAC Code Loader

This block is the digital front end of a single-channel voltage-output DAC. A host sends each code as a serial word over three wires: an active-low chip select, a serial clock and a data line. The block shifts the bits into a holding register. A word is accepted only if the frame carried exactly the right number of bits. A second register, the output code register, drives the converter. It copies the holding register when the load strobe falls, so a new code can be staged early and applied at a chosen moment.

An active-low clear input forces the output code register to a parameter-selected midscale value. The clear acts at once, without waiting for the clock. While the clear is held low, every load strobe is ignored. The clear does not touch the holding register or a frame in progress. All serial and control pins come through synchronizers into the block clock domain. Two state machines run the block. The frame machine has states FR_IDLE, FR_SHIFT and FR_OVER, with transitions select-fall (FR_IDLE to FR_SHIFT), overlength-bit (FR_SHIFT to FR_OVER) and select-rise (FR_SHIFT or FR_OVER to FR_IDLE, committing only from FR_SHIFT at full count). The load machine has states LD_ARMED and LD_HELD, with transitions clear-assert (LD_ARMED to LD_HELD) and clear-release (LD_HELD to LD_ARMED).

Top module: `serial_dac_input`

## Requirements
- R1: After reset, `dac_code` equals the parameter `MID_CODE`. `MID_CODE` defaults to half scale, 2^(WORD_W-1), which is 16'h8000 for 16 bits.
- R2: While `cs_n` is low, `din` is sampled on each rising edge of `sclk`, most significant bit first. When `cs_n` rises after exactly `WORD_W` bits, the holding register takes that word.
- R3: A frame that ends with fewer than `WORD_W` bits, including one with no bits, leaves the holding register unchanged.
- R4: A frame with more than `WORD_W` bits leaves the holding register unchanged.
- R5: Rising edges of `sclk` while `cs_n` is high have no effect.
- R6: A completed frame alone does not change `dac_code`. A falling edge of `ldac_n` copies the holding register into `dac_code`.
- R7: Loading is triggered by the edge of `ldac_n`, not its level. While `ldac_n` stays low, further frames do not reach `dac_code`.
- R8: When `clr_n` goes low, `dac_code` becomes `MID_CODE` without waiting for a clock edge. It stays at `MID_CODE` while `clr_n` is low.
- R9: A falling edge of `ldac_n` while `clr_n` is low is ignored. If `ldac_n` is already low when `clr_n` rises, no load happens.
- R10: A clear during a frame does not disturb that frame. The word still reaches the holding register, and a later load applies it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial frame select, active low |
| sclk | input | 1 | Serial bit clock, sampled on its rising edge |
| din | input | 1 | Serial data, MSB first |
| ldac_n | input | 1 | Load strobe, falling edge copies holding register to output |
| clr_n | input | 1 | Asynchronous active-low clear to midscale |
| dac_code | output | WORD_W | Output code register driving the converter |

## Verification
The bench builds the block with `WORD_W` = 4 and `MID_CODE` = 4'h6. The non-default midscale exposes any design that ignores the parameter. The narrow word lets the bench load every possible code and sweep every frame length from zero up to two bits past a full word. That sweep reaches every branch of the frame machine. The bench also drives clear pulses against load strobes in every order, including a clear that arrives in the middle of a frame.

// File: rtl/sdi_pkg.sv
package sdi_pkg;

    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_SHIFT = 2'd1,
        FR_OVER  = 2'd2
    } frame_state_e;

    typedef enum logic {
        LD_ARMED = 1'b0,
        LD_HELD  = 1'b1
    } load_state_e;

endpackage

// File: rtl/sdi_sync.sv
module sdi_sync #(
    parameter int             N       = 5,
    parameter int             STAGES  = 2,
    parameter logic [N-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q,
    output logic [N-1:0] q_prev
);

    generate
        for (genvar b = 0; b < N; b++) begin : g_bit
            logic [STAGES-1:0] chain;
            logic              last;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= {STAGES{RST_VAL[b]}};
                    last  <= RST_VAL[b];
                end else begin
                    chain <= {chain[STAGES-2:0], d[b]};
                    last  <= chain[STAGES-1];
                end
            end

            assign q[b]      = chain[STAGES-1];
            assign q_prev[b] = last;
        end
    endgenerate

endmodule

// File: rtl/sdi_frame.sv
module sdi_frame
    import sdi_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              cs_rise,
    input  logic              sclk_rise,
    input  logic              din_s,
    output logic [WORD_W-1:0] hold_word
);

    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

    frame_state_e      state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] shreg_q;
    logic              commit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FR_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        commit  = 1'b0;
        unique case (state_q)
            FR_IDLE: begin
                if (!cs_s) state_d = FR_SHIFT;
            end
            FR_SHIFT: begin
                if (cs_rise) begin
                    state_d = FR_IDLE;
                    commit  = (cnt_q == FULL);
                end else if (sclk_rise && cnt_q == FULL) begin
                    state_d = FR_OVER;
                end
            end
            FR_OVER: begin
                if (cs_rise) state_d = FR_IDLE;
            end
            default: state_d = FR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            shreg_q   <= '0;
            hold_word <= '0;
        end else begin
            if (state_q == FR_IDLE) begin
                cnt_q <= '0;
            end else if (state_q == FR_SHIFT && !cs_rise && sclk_rise
                         && cnt_q != FULL) begin
                shreg_q <= {shreg_q[WORD_W-2:0], din_s};
                cnt_q   <= cnt_q + 1'b1;
            end
            if (commit) hold_word <= shreg_q;
        end
    end

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL);

    // R3
    hold_only_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(hold_word) |-> $past(commit));

    // R5
    shreg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && $past(cs_s)) |-> $stable(shreg_q));

endmodule

// File: rtl/sdi_load_ctrl.sv
module sdi_load_ctrl
    import sdi_pkg::*;
#(
    parameter int                WORD_W   = 16,
    parameter logic [WORD_W-1:0] MID_CODE = WORD_W'(1) << (WORD_W - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              clr_s,
    input  logic              ldac_fall,
    input  logic [WORD_W-1:0] hold_word,
    output logic [WORD_W-1:0] dac_code
);

    load_state_e state_q, state_d;
    logic        load_fire;
    logic        arst_n;

    assign arst_n = rst_n & clr_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LD_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        load_fire = 1'b0;
        unique case (state_q)
            LD_ARMED: begin
                if (!clr_s) state_d = LD_HELD;
                else        load_fire = ldac_fall;
            end
            LD_HELD: begin
                if (clr_s) state_d = LD_ARMED;
            end
            default: state_d = LD_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)        dac_code <= MID_CODE;
        else if (load_fire) dac_code <= hold_word;
    end

    // R8
    clear_holds_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> dac_code == MID_CODE);

    // R6
    code_changes_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(dac_code) && clr_n && $past(clr_n)) |-> $past(load_fire));

    // R9
    held_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LD_HELD) |=> $stable(dac_code) || !clr_n);

endmodule

// File: rtl/serial_dac_input.sv
module serial_dac_input #(
    parameter int                WORD_W      = 16,
    parameter logic [WORD_W-1:0] MID_CODE    = WORD_W'(1) << (WORD_W - 1),
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    input  logic              ldac_n,
    input  logic              clr_n,
    output logic [WORD_W-1:0] dac_code
);

    localparam int NPIN = 5;
    localparam int P_DIN = 0, P_SCLK = 1, P_CS = 2, P_LDAC = 3, P_CLR = 4;
    localparam logic [NPIN-1:0] PIN_IDLE = 5'b11100;

    logic [NPIN-1:0]   pins_s, pins_p;
    logic [WORD_W-1:0] hold_word;

    sdi_sync #(
        .N       (NPIN),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_IDLE)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d      ({clr_n, ldac_n, cs_n, sclk, din}),
        .q      (pins_s),
        .q_prev (pins_p)
    );

    sdi_frame #(
        .WORD_W (WORD_W)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_s      (pins_s[P_CS]),
        .cs_rise   (pins_s[P_CS] & ~pins_p[P_CS]),
        .sclk_rise (pins_s[P_SCLK] & ~pins_p[P_SCLK]),
        .din_s     (pins_s[P_DIN]),
        .hold_word (hold_word)
    );

    sdi_load_ctrl #(
        .WORD_W   (WORD_W),
        .MID_CODE (MID_CODE)
    ) u_load (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_n     (clr_n),
        .clr_s     (pins_s[P_CLR]),
        .ldac_fall (~pins_s[P_LDAC] & pins_p[P_LDAC]),
        .hold_word (hold_word),
        .dac_code  (dac_code)
    );

endmodule

// File: tb/serial_dac_input_bench.sv
module serial_dac_input_bench;

    localparam int         W   = 4;
    localparam logic [W-1:0] MID = 4'h6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs_n = 1'b1, sclk = 1'b0, din = 1'b0, ldac_n = 1'b1, clr_n = 1'b1;
    logic [W-1:0] dac_code;

    int           n_run = 0, n_fail = 0;
    logic [W-1:0] m_hold = '0, m_dac = MID;
    bit           done = 1'b0;

    always #2 clk = ~clk;

    serial_dac_input #(.WORD_W(W), .MID_CODE(MID)) u_serial_dac_input (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .ldac_n(ldac_n), .clr_n(clr_n), .dac_code(dac_code)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [W-1:0] exp);
        @(negedge clk);
        n_run++;
        if (dac_code !== exp) begin
            n_fail++;
            $display("FAIL %s: dac_code=%h expected=%h", req, dac_code, exp);
        end
    endtask

    task automatic send_bits(input int nbits, input logic [7:0] bits);
        for (int i = nbits - 1; i >= 0; i--) begin
            din = bits[i];
            wait_clk(4);
            sclk = 1'b1;
            wait_clk(4);
            sclk = 1'b0;
        end
    endtask

    task automatic frame(input int nbits, input logic [7:0] bits);
        cs_n = 1'b0;
        wait_clk(4);
        send_bits(nbits, bits);
        wait_clk(4);
        cs_n = 1'b1;
        wait_clk(8);
        if (nbits == W) m_hold = bits[W-1:0];
    endtask

    task automatic pulse_ldac();
        ldac_n = 1'b0;
        wait_clk(8);
        ldac_n = 1'b1;
        wait_clk(8);
        if (clr_n) m_dac = m_hold;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        check("R1 reset midscale", MID);

        // R2 / R6: every code, staged then applied
        for (int c = 0; c < (1 << W); c++) begin
            frame(W, 8'(c));
            check("R6 frame alone keeps output", m_dac);
            pulse_ldac();
            check("R2 full word loaded", 4'(c));
        end

        // R3 / R4: every wrong frame length
        frame(W, 8'h0A);
        pulse_ldac();
        for (int n = 0; n <= W + 2; n++) begin
            if (n != W) begin
                frame(n, 8'hF5);
                pulse_ldac();
                if (n < W) check("R3 short frame discarded", m_dac);
                else       check("R4 long frame discarded", m_dac);
            end
        end

        // R5: clock edges with select high
        for (int k = 0; k < 6; k++) begin
            din = k[0];
            wait_clk(4); sclk = 1'b1; wait_clk(4); sclk = 1'b0;
        end
        pulse_ldac();
        check("R5 sclk ignored while deselected", m_dac);
        frame(W, 8'h3);
        pulse_ldac();
        check("R5 next frame clean after idle clocks", 4'h3);

        // R7: level held low does not reload
        ldac_n = 1'b0;
        wait_clk(8);
        m_dac = m_hold;
        frame(W, 8'hC);
        check("R7 held strobe no reload", m_dac);
        ldac_n = 1'b1;
        wait_clk(8);
        pulse_ldac();
        check("R7 new edge loads", 4'hC);

        // R8: asynchronous clear
        clr_n = 1'b0;
        #1;
        n_run++;
        if (dac_code !== MID) begin
            n_fail++;
            $display("FAIL R8 clear not immediate: dac_code=%h expected=%h", dac_code, MID);
        end
        wait_clk(6);
        check("R8 clear holds midscale", MID);

        // R9: strobes during clear ignored
        frame(W, 8'h9);
        pulse_ldac();
        check("R9 strobe during clear ignored", MID);
        ldac_n = 1'b0;
        wait_clk(8);
        clr_n = 1'b1;
        wait_clk(10);
        check("R9 strobe low across release no load", MID);
        ldac_n = 1'b1;
        wait_clk(8);
        m_dac = MID;
        pulse_ldac();
        check("R9 load after release", 4'h9);

        // R10: clear mid-frame
        cs_n = 1'b0;
        wait_clk(4);
        send_bits(2, 8'h2);
        clr_n = 1'b0;
        wait_clk(6);
        check("R10 clear mid-frame gives midscale", MID);
        send_bits(2, 8'h3);
        wait_clk(4);
        cs_n = 1'b1;
        wait_clk(8);
        m_hold = 4'hB;
        clr_n = 1'b1;
        wait_clk(10);
        check("R10 output stays midscale after release", MID);
        pulse_ldac();
        check("R10 frame survives clear", 4'hB);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule